// File: doc/BRIEF.md
# Serial Converter Readout Port

This block is the digital front of a 12-bit successive-approximation converter with a three-wire serial port. A host frames each conversion by pulling an active-low select input low and then toggling a serial clock. The block returns a fixed frame on a serial data line that the host can tri-state. It reports a track/hold status and the power mode, and it flags whether the current frame carries real data. The testbench supplies the parallel sample value in place of the analog core.

A select fall starts a frame. On that fall the sample is captured, the data line is enabled and the converter goes to hold. Frame bits advance on falling serial-clock edges, so the host captures them on the next rising edge. The block goes back to track after a fixed number of rising edges. If select is released while the frame is inside a window of falling edges, the block drops into shutdown. The next frame wakes it up but carries no valid data. The same holds for the first frame after reset.

Both pins are brought into the `clk_i` domain through a synchronizer of configurable depth and then edge-detected. All counting is done in that domain.

Top module: `sar_serial_port`

## Requirements
- R1: After reset, sdo_oe_o, hold_o, shutdown_o and data_valid_o are all 0, and sdo_o is 0 while sdo_oe_o is 0.
- R2: On a select fall, sdo_oe_o and hold_o become 1 and sample_i is captured. Later changes of sample_i do not alter that frame.
- R3: After k falling serial-clock edges in a frame (k = 0 at the select fall), sdo_o carries frame position k. Positions 0..2 are 0, positions 3..14 are sample bits 11 down to 0 (MSB first), and position 15 is 0. sdo_o does not change on rising edges.
- R4: hold_o returns to 0 on the 13th rising serial-clock edge of a frame, or on the select rise if that comes first.
- R5: sdo_oe_o returns to 0 after the 16th falling edge or on the select rise, whichever comes first. Later falling edges in the same frame do not re-enable it.
- R6: On a select rise after exactly 10 to 14 falling edges (inclusive), shutdown_o becomes 1. A select rise after any other count leaves it 0.
- R7: During a frame, data_valid_o is 0 for the first frame after reset and for the first frame after a shutdown, and 1 otherwise. It is 0 between frames.
- R8: Serial-clock edges while select is high are ignored. Outputs stay put, and the next frame counts its edges from zero.
- R9: Data is straight binary. Codes 0 and 4095 are shifted out unchanged as all-zero and all-one data fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Active-low frame select from the host |
| sclk_i | input | 1 | Serial clock from the host, idles high |
| sample_i | input | DATA_W | Parallel sample standing in for the analog core |
| sdo_o | output | 1 | Serial data, 0 when not enabled |
| sdo_oe_o | output | 1 | Output enable for the serial data pad |
| hold_o | output | 1 | 1 in hold, 0 in track |
| shutdown_o | output | 1 | 1 when in shutdown mode |
| data_valid_o | output | 1 | Current frame carries a real conversion |

## Verification
The bench builds the block with its default widths (12 data bits, 16-position frame, track on edge 13, shutdown window 10..14) and a two-stage synchronizer. It holds each serial-clock half period for four system clocks, which stays above the three-cycle pin-to-state latency. With this setup every frame position can be checked against an arithmetic model over more than a hundred sample codes. It also allows select-release points swept across every falling-edge count from 8 to 18, which covers both edges of the shutdown window and the early and late tri-state paths.

// File: rtl/sar_port_pkg.sv
package sar_port_pkg;
  typedef enum logic {
    MODE_NORMAL   = 1'b0,
    MODE_SHUTDOWN = 1'b1
  } pwr_mode_e;
endpackage

// File: rtl/sar_pin_sync.sv
module sar_pin_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= RST_VAL;
    else         chain_q[0] <= pin_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= RST_VAL;
      else         chain_q[g] <= chain_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= chain_q[STAGES-1];
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;
endmodule

// File: rtl/sar_frame_ctrl.sv
module sar_frame_ctrl
  import sar_port_pkg::*;
#(
  parameter int FRAME_LEN  = 16,
  parameter int TRACK_EDGE = 13,
  parameter int SD_FIRST   = 10,
  parameter int SD_LAST    = 14
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cs_fall_i,
  input  logic      cs_rise_i,
  input  logic      sclk_fall_i,
  input  logic      sclk_rise_i,
  output logic      active_o,
  output logic      load_o,
  output logic      shift_o,
  output logic      oe_o,
  output logic      hold_o,
  output pwr_mode_e mode_o,
  output logic      valid_o
);
  localparam int CNT_W = $clog2(FRAME_LEN + 1);
  localparam int RISE_W = $clog2(TRACK_EDGE + 1);
  localparam logic [CNT_W-1:0]  FALL_MAX  = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0]  FALL_LAST = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0]  SD_LO     = CNT_W'(SD_FIRST);
  localparam logic [CNT_W-1:0]  SD_HI     = CNT_W'(SD_LAST);
  localparam logic [RISE_W-1:0] RISE_MAX  = RISE_W'(TRACK_EDGE);
  localparam logic [RISE_W-1:0] RISE_LAST = RISE_W'(TRACK_EDGE - 1);

  logic              active_q, oe_q, hold_q, valid_q, dummy_q;
  pwr_mode_e         mode_q;
  logic [CNT_W-1:0]  fall_cnt_q;
  logic [RISE_W-1:0] rise_cnt_q;
  logic              fall_adv, rise_adv, in_sd_win;

  assign fall_adv  = active_q & ~cs_rise_i & sclk_fall_i & (fall_cnt_q < FALL_MAX);
  assign rise_adv  = active_q & ~cs_rise_i & sclk_rise_i & (rise_cnt_q < RISE_MAX);
  assign in_sd_win = (fall_cnt_q >= SD_LO) && (fall_cnt_q <= SD_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      oe_q       <= 1'b0;
      hold_q     <= 1'b0;
      valid_q    <= 1'b0;
      dummy_q    <= 1'b1;
      mode_q     <= MODE_NORMAL;
      fall_cnt_q <= '0;
      rise_cnt_q <= '0;
    end else if (cs_fall_i) begin
      active_q   <= 1'b1;
      oe_q       <= 1'b1;
      hold_q     <= 1'b1;
      valid_q    <= ~dummy_q;
      dummy_q    <= 1'b0;
      mode_q     <= MODE_NORMAL;
      fall_cnt_q <= '0;
      rise_cnt_q <= '0;
    end else if (active_q && cs_rise_i) begin
      active_q <= 1'b0;
      oe_q     <= 1'b0;
      hold_q   <= 1'b0;
      valid_q  <= 1'b0;
      if (in_sd_win) begin
        mode_q  <= MODE_SHUTDOWN;
        dummy_q <= 1'b1;
      end
    end else begin
      if (fall_adv) begin
        fall_cnt_q <= fall_cnt_q + 1'b1;
        if (fall_cnt_q == FALL_LAST) oe_q <= 1'b0;
      end
      if (rise_adv) begin
        rise_cnt_q <= rise_cnt_q + 1'b1;
        if (rise_cnt_q == RISE_LAST) hold_q <= 1'b0;
      end
    end
  end

  assign active_o = active_q;
  assign load_o   = cs_fall_i;
  assign shift_o  = fall_adv;
  assign oe_o     = oe_q;
  assign hold_o   = hold_q;
  assign mode_o   = mode_q;
  assign valid_o  = valid_q;
endmodule

// File: rtl/sar_shift_out.sv
module sar_shift_out #(
  parameter int DATA_W     = 12,
  parameter int LEAD_ZEROS = 3,
  parameter int FRAME_LEN  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic              oe_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              sdo_o
);
  localparam int TOP_POS = FRAME_LEN - 1 - LEAD_ZEROS;

  logic [FRAME_LEN-1:0] shreg_q, frame_w;

  always_comb begin
    frame_w = '0;
    frame_w[TOP_POS -: DATA_W] = sample_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      shreg_q <= '0;
    else if (load_i)  shreg_q <= frame_w;
    else if (shift_i) shreg_q <= {shreg_q[FRAME_LEN-2:0], 1'b0};
  end

  assign sdo_o = oe_i & shreg_q[FRAME_LEN-1];
endmodule

// File: rtl/sar_serial_port.sv
module sar_serial_port
  import sar_port_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int LEAD_ZEROS  = 3,
  parameter int FRAME_LEN   = 16,
  parameter int TRACK_EDGE  = 13,
  parameter int SD_FIRST    = 10,
  parameter int SD_LAST     = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              hold_o,
  output logic              shutdown_o,
  output logic              data_valid_o
);
  logic      cs_lvl, cs_rise, cs_fall;
  logic      sclk_lvl, sclk_rise, sclk_fall;
  logic      active, load, shift, oe;
  pwr_mode_e mode;

  sar_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk_i, .rst_ni, .pin_i(cs_ni),
    .level_o(cs_lvl), .rise_o(cs_rise), .fall_o(cs_fall)
  );

  sar_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sclk_sync (
    .clk_i, .rst_ni, .pin_i(sclk_i),
    .level_o(sclk_lvl), .rise_o(sclk_rise), .fall_o(sclk_fall)
  );

  sar_frame_ctrl #(
    .FRAME_LEN(FRAME_LEN), .TRACK_EDGE(TRACK_EDGE),
    .SD_FIRST(SD_FIRST), .SD_LAST(SD_LAST)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
    .sclk_fall_i(sclk_fall), .sclk_rise_i(sclk_rise),
    .active_o(active), .load_o(load), .shift_o(shift),
    .oe_o(oe), .hold_o(hold_o), .mode_o(mode), .valid_o(data_valid_o)
  );

  sar_shift_out #(
    .DATA_W(DATA_W), .LEAD_ZEROS(LEAD_ZEROS), .FRAME_LEN(FRAME_LEN)
  ) u_shift (
    .clk_i, .rst_ni, .load_i(load), .shift_i(shift), .oe_i(oe),
    .sample_i, .sdo_o
  );

  assign sdo_oe_o   = oe;
  assign shutdown_o = (mode == MODE_SHUTDOWN);

  // levels kept for observability in the bound checker
  logic unused_lvl;
  assign unused_lvl = cs_lvl ^ sclk_lvl;
endmodule

// File: rtl/sar_serial_port_chk.sv
module sar_serial_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_lvl_i,
  input logic cs_fall_i,
  input logic cs_rise_i,
  input logic sclk_fall_i,
  input logic sclk_rise_i,
  input logic active_i,
  input logic sdo_o,
  input logic sdo_oe_o,
  input logic hold_o,
  input logic shutdown_o,
  input logic data_valid_o
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> (!sdo_oe_o && !sdo_o && !data_valid_o));

  // R2
  frame_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall_i |=> (sdo_oe_o && hold_o));

  // R2
  oe_rise_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdo_oe_o) |-> $past(cs_fall_i));

  // R3
  sdo_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdo_oe_o && !sclk_fall_i && !cs_fall_i && !cs_rise_i) |=> $stable(sdo_o));

  // R4
  hold_fall_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_o) |-> $past(sclk_rise_i || cs_rise_i));

  // R5
  release_on_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && cs_rise_i) |=> !sdo_oe_o);

  // R6
  sd_entry_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(shutdown_o) |-> $past(cs_rise_i));

  // R6
  sd_exit_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(shutdown_o) |-> $past(cs_fall_i));

  // R8
  cs_high_inert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_lvl_i && !cs_rise_i && !active_i) |=> (!sdo_oe_o && !hold_o));
endmodule

bind sar_serial_port sar_serial_port_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cs_lvl_i     (cs_lvl),
  .cs_fall_i    (cs_fall),
  .cs_rise_i    (cs_rise),
  .sclk_fall_i  (sclk_fall),
  .sclk_rise_i  (sclk_rise),
  .active_i     (active),
  .sdo_o        (sdo_o),
  .sdo_oe_o     (sdo_oe_o),
  .hold_o       (hold_o),
  .shutdown_o   (shutdown_o),
  .data_valid_o (data_valid_o)
);

// File: tb/sar_serial_port_tb_top.sv
module sar_serial_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b1;
  logic [11:0] sample = '0;
  logic        sdo, sdo_oe, hold, sd, valid;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;
  bit  dummy_m = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  sar_serial_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk),
    .sample_i(sample), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .hold_o(hold),
    .shutdown_o(sd), .data_valid_o(valid)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%0b exp=%0b", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic exp_bit(input logic [11:0] code, input int pos);
    if (pos < 3 || pos > 14) return 1'b0;
    return code[14 - pos];
  endfunction

  task automatic run_frame(input logic [11:0] code, input int nfalls);
    logic  vexp, prev;
    string dtag;
    dtag = (code == 12'h000 || code == 12'hFFF) ? "R9" : "R3";
    sample = code;
    cs_n = 1'b0;
    step(HALF);
    vexp = !dummy_m;
    dummy_m = 0;
    chk("R2", "oe at start", sdo_oe, 1'b1);
    chk("R2", "hold at start", hold, 1'b1);
    chk("R3", "pos0", sdo, 1'b0);
    chk("R7", "valid", valid, vexp);
    chk("R6", "awake", sd, 1'b0);
    sample = ~code;
    for (int i = 1; i <= nfalls; i++) begin
      sclk = 1'b0;
      step(HALF);
      if (i < 16) begin
        chk("R5", "oe mid", sdo_oe, 1'b1);
        chk(dtag, $sformatf("pos%0d", i), sdo, exp_bit(code, i));
      end else begin
        chk("R5", "oe after last fall", sdo_oe, 1'b0);
      end
      prev = sdo;
      sclk = 1'b1;
      step(HALF);
      chk("R4", $sformatf("hold after rise %0d", i), hold, (i < 13) ? 1'b1 : 1'b0);
      chk("R3", "steady on rise", sdo, prev);
    end
    cs_n = 1'b1;
    step(HALF);
    chk("R5", "oe after cs rise", sdo_oe, 1'b0);
    chk("R4", "track after cs rise", hold, 1'b0);
    chk("R7", "valid idle", valid, 1'b0);
    chk("R6", $sformatf("mode after %0d falls", nfalls), sd,
        (nfalls >= 10 && nfalls <= 14) ? 1'b1 : 1'b0);
    if (nfalls >= 10 && nfalls <= 14) dummy_m = 1;
    step(HALF);
  endtask

  task automatic report;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL R1 watchdog act=running exp=finished");
    report();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(HALF);
    // R1 reset state
    chk("R1", "oe reset", sdo_oe, 1'b0);
    chk("R1", "hold reset", hold, 1'b0);
    chk("R1", "sd reset", sd, 1'b0);
    chk("R1", "valid reset", valid, 1'b0);
    chk("R1", "sdo reset", sdo, 1'b0);

    // R7 first frame after reset is dummy
    run_frame(12'hA5C, 16);

    // R9 corner codes, R3 sweep
    run_frame(12'h000, 16);
    run_frame(12'hFFF, 16);
    for (int b = 0; b < 12; b++) run_frame(12'(1 << b), 16);
    for (int c = 1; c < 4096; c += 37) run_frame(12'(c), 16);

    // R8 clock edges with select high
    for (int t = 0; t < 6; t++) begin
      sclk = ~sclk;
      step(HALF);
      chk("R8", "oe idle", sdo_oe, 1'b0);
      chk("R8", "hold idle", hold, 1'b0);
      chk("R8", "sd idle", sd, 1'b0);
    end
    sclk = 1'b1;
    step(HALF);
    sample = 12'hFFF;
    cs_n = 1'b0;
    step(HALF);
    for (int i = 1; i <= 3; i++) begin
      sclk = 1'b0;
      step(HALF);
      chk("R8", $sformatf("count restart pos%0d", i), sdo, (i == 3) ? 1'b1 : 1'b0);
      sclk = 1'b1;
      step(HALF);
    end
    cs_n = 1'b1;
    step(2 * HALF);

    // R6 select release swept across the window; R5 early release
    for (int n = 0; n <= 18; n++) run_frame(12'h5A3, n);
    run_frame(12'h3C6, 11);
    run_frame(12'h3C6, 11);
    run_frame(12'h3C6, 16);

    report();
  end
endmodule